// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Checker

This block is the issue-control decision for a statically scheduled, two-wide, in-order pipeline. Fetch delivers a 64-bit packet of two 32-bit instructions from an 8-byte-aligned address. Slot 0 carries an ALU or branch operation and slot 1 carries a load or a store. Either slot may hold a nop instead. The checker looks at the decoded register fields of the packet in decode and at the memory operation currently in execute. Each cycle it decides one of four things:

- issue the whole packet;
- issue only the ALU half and keep the memory half for the next cycle;
- stall the whole packet;
- flag the packet as badly formed.

Forwarding handles every dependency between packets except one: a load whose result is read by the very next packet. Forwarding also cannot give the memory slot the result of the ALU slot in the same packet, so such a packet is split over two cycles. A single registered bit remembers that the memory half of a split packet is still waiting. All four outputs are combinational from the inputs and that bit. When hold_fetch is high, the front end keeps the same packet in decode for the next cycle. When it is low and the packet is valid, the packet has been used up and the following packet may enter decode.

Top module: `dual_issue_hazard_chk`

## Requirements
- R1: A valid, well-formed packet with no hazard issues both slots in the same cycle (issue_slot0=1, issue_slot1=1, hold_fetch=0).
- R2: Slot operation codes are: 2'b00 nop, 2'b01 ALU or branch, 2'b10 load, 2'b11 store. A valid packet is malformed if any of these holds:
  - the low three address bits are not zero;
  - slot 0 holds a load or a store;
  - slot 1 holds an ALU op.
  When a valid packet is malformed, malformed=1 and nothing issues or holds.
- R3: A slot-0 ALU op writes a register. If the slot-1 load reads that register as its base, or the slot-1 store reads it as base or data, the packet splits. In the first cycle only slot 0 issues, with hold_fetch=1.
- R4: In the cycle after the first half of a split, slot 0 does not issue. Slot 1 issues with hold_fetch=0, unless that memory half meets a load-use hazard; in that case it stalls with hold_fetch=1 and stays pending.
- R5: If execute holds a load whose destination is read by either slot of the packet in decode, the whole packet stalls for one cycle (no issue, hold_fetch=1).
- R6: A register written by a non-load operation in execute causes no stall.
- R7: Register 0 never forms a dependency, whether it is the producer's destination or a consumer's source.
- R8: Register fields that a slot does not read are ignored: both sources of a nop slot and the data source of a load.
- R9: Reset clears the pending memory half. After reset, a packet is judged as a fresh packet.
- R10: With no valid packet, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Decode holds a packet |
| pkt_pc_lo | input | ALIGN_W (3) | Low address bits of the packet |
| s0_op | input | 2 | Slot-0 operation code |
| s0_dst | input | REG_W | Slot-0 destination register |
| s0_src_a | input | REG_W | Slot-0 first source |
| s0_src_b | input | REG_W | Slot-0 second source |
| s1_op | input | 2 | Slot-1 operation code |
| s1_src_base | input | REG_W | Slot-1 address base register |
| s1_src_data | input | REG_W | Slot-1 store data register |
| ex_load | input | 1 | Execute holds a load |
| ex_load_dst | input | REG_W | Destination of the load in execute |
| issue_slot0 | output | 1 | Slot 0 enters the ALU pipe this cycle |
| issue_slot1 | output | 1 | Slot 1 enters the memory pipe this cycle |
| hold_fetch | output | 1 | Keep the current packet in decode next cycle |
| malformed | output | 1 | Packet violates the slot or alignment format |

## Verification
The assertions assume two things about the front end. First, once hold_fetch is high, the packet stays valid and its fields stay unchanged into the next cycle. Second, a packet never becomes malformed while its memory half is pending. The bench keeps to both. Every packet is replayed until hold_fetch drops. After each stall or first half, ex_load is cleared, because the bubble or the ALU-only half is what moves into execute. Stimulus uses 3-bit register numbers, so hazards, register-0 cases and misaligned addresses turn up often. Directed cases cover a load-use stall on a pending memory half and a reset in the middle of a split.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   typedef enum logic [1:0] {
      OPC_NOP   = 2'b00,
      OPC_ALU   = 2'b01,
      OPC_LOAD  = 2'b10,
      OPC_STORE = 2'b11
   } op_class_e;

   typedef struct packed {
      logic go0;
      logic go1;
      logic keep;
   } issue_t;

   function automatic logic op_is_mem(op_class_e c);
      return (c == OPC_LOAD) || (c == OPC_STORE);
   endfunction

endpackage

// File: rtl/hzd_reg_match.sv
module hzd_reg_match #(
   parameter int REG_W      = 5,
   parameter int N_RD       = 2,
   parameter bit R0_IS_ZERO = 1'b1
) (
   input  logic                  wr_en,
   input  logic [REG_W-1:0]      wr_reg,
   input  logic [N_RD-1:0]       rd_en,
   input  logic [N_RD*REG_W-1:0] rd_regs,
   output logic                  hit
);

   logic            wr_live;
   logic [N_RD-1:0] per_rd;

   if (REG_W < 1 || N_RD < 1) begin : g_bad_cfg
      $error("hzd_reg_match: REG_W and N_RD must be at least 1");
   end

   if (R0_IS_ZERO) begin : g_r0_zero
      assign wr_live = wr_en && (wr_reg != '0);
   end else begin : g_r0_plain
      assign wr_live = wr_en;
   end

   for (genvar k = 0; k < N_RD; k++) begin : g_rd
      assign per_rd[k] = rd_en[k] && (rd_regs[k*REG_W +: REG_W] == wr_reg);
   end

   assign hit = wr_live && (|per_rd);

endmodule

// File: rtl/hzd_pkt_format.sv
module hzd_pkt_format
   import hzd_pkg::*;
#(
   parameter int ALIGN_W     = 3,
   parameter bit CHECK_ALIGN = 1'b1
) (
   input  logic               pkt_valid,
   input  logic [ALIGN_W-1:0] pc_lo,
   input  op_class_e          op0,
   input  op_class_e          op1,
   output logic               malformed
);

   logic misaligned;
   logic slot_bad;

   if (ALIGN_W < 1) begin : g_bad_cfg
      $error("hzd_pkt_format: ALIGN_W must be at least 1");
   end

   if (CHECK_ALIGN) begin : g_align
      assign misaligned = (pc_lo != '0);
   end else begin : g_no_align
      assign misaligned = 1'b0;
   end

   assign slot_bad  = op_is_mem(op0) || (op1 == OPC_ALU);
   assign malformed = pkt_valid && (misaligned || slot_bad);

endmodule

// File: rtl/hzd_issue_seq.sv
module hzd_issue_seq
   import hzd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pkt_valid,
   input  logic malformed,
   input  logic lu_slot0,
   input  logic lu_slot1,
   input  logic intra_dep,
   output logic issue_slot0,
   output logic issue_slot1,
   output logic hold_fetch
);

   logic   pend_q;
   logic   pend_d;
   issue_t dec;

   always_comb begin
      dec    = '0;
      pend_d = pend_q;
      if (pkt_valid && !malformed) begin
         if (pend_q) begin
            if (lu_slot1) begin
               dec.keep = 1'b1;
            end else begin
               dec.go1 = 1'b1;
               pend_d  = 1'b0;
            end
         end else if (lu_slot0 || lu_slot1) begin
            dec.keep = 1'b1;
         end else if (intra_dep) begin
            dec.go0  = 1'b1;
            dec.keep = 1'b1;
            pend_d   = 1'b1;
         end else begin
            dec.go0 = 1'b1;
            dec.go1 = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
      end
   end

   assign issue_slot0 = dec.go0;
   assign issue_slot1 = dec.go1;
   assign hold_fetch  = dec.keep;

   // R2: a malformed packet issues nothing and is not held
   p_malformed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      malformed |-> (!issue_slot0 && !issue_slot1 && !hold_fetch));

   // R3: a lone slot-0 issue leaves the memory half pending
   p_split_pends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_slot0 && !issue_slot1) |=> pend_q);

   // R3: assumption on the front end - a held packet stays valid
   p_hold_keeps_pkt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hold_fetch |=> pkt_valid);

   // R4: while the memory half is pending, slot 0 never issues again
   p_pending_no_alu_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !issue_slot0);

   // R4: the pending half completes once it is not held
   p_pending_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && pkt_valid && !hold_fetch) |=> !pend_q);

   // R5: a stall is all-or-nothing
   p_stall_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_fetch && !issue_slot0) |-> !issue_slot1);

   // R9: nothing is pending right after reset
   p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !pend_q);

   // R10: no packet, no activity
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid |-> (!issue_slot0 && !issue_slot1 && !hold_fetch));

endmodule

// File: rtl/dual_issue_hazard_chk.sv
module dual_issue_hazard_chk
   import hzd_pkg::*;
#(
   parameter int  REG_W       = 5,
   parameter int  INSTR_W     = 32,
   parameter bit  R0_IS_ZERO  = 1'b1,
   parameter bit  CHECK_ALIGN = 1'b1,
   localparam int PKT_BYTES   = 2 * INSTR_W / 8,
   localparam int ALIGN_W     = $clog2(PKT_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pkt_valid,
   input  logic [ALIGN_W-1:0] pkt_pc_lo,
   input  logic [1:0]         s0_op,
   input  logic [REG_W-1:0]   s0_dst,
   input  logic [REG_W-1:0]   s0_src_a,
   input  logic [REG_W-1:0]   s0_src_b,
   input  logic [1:0]         s1_op,
   input  logic [REG_W-1:0]   s1_src_base,
   input  logic [REG_W-1:0]   s1_src_data,
   input  logic               ex_load,
   input  logic [REG_W-1:0]   ex_load_dst,
   output logic               issue_slot0,
   output logic               issue_slot1,
   output logic               hold_fetch,
   output logic               malformed
);

   if (INSTR_W < 8 || (INSTR_W % 8) != 0) begin : g_bad_instr
      $error("dual_issue_hazard_chk: INSTR_W must be a whole number of bytes");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("dual_issue_hazard_chk: REG_W must be at least 1");
   end

   op_class_e op0;
   op_class_e op1;
   logic      alu0;
   logic      mem1;
   logic      st1;
   logic      lu_slot0;
   logic      lu_slot1;
   logic      intra_dep;

   assign op0  = op_class_e'(s0_op);
   assign op1  = op_class_e'(s1_op);
   assign alu0 = (op0 == OPC_ALU);
   assign mem1 = op_is_mem(op1);
   assign st1  = (op1 == OPC_STORE);

   hzd_pkt_format #(
      .ALIGN_W     (ALIGN_W),
      .CHECK_ALIGN (CHECK_ALIGN)
   ) u_format (
      .pkt_valid (pkt_valid),
      .pc_lo     (pkt_pc_lo),
      .op0       (op0),
      .op1       (op1),
      .malformed (malformed)
   );

   hzd_reg_match #(.REG_W(REG_W), .N_RD(2), .R0_IS_ZERO(R0_IS_ZERO)) u_lu_alu (
      .wr_en   (ex_load),
      .wr_reg  (ex_load_dst),
      .rd_en   ({alu0, alu0}),
      .rd_regs ({s0_src_b, s0_src_a}),
      .hit     (lu_slot0)
   );

   hzd_reg_match #(.REG_W(REG_W), .N_RD(2), .R0_IS_ZERO(R0_IS_ZERO)) u_lu_mem (
      .wr_en   (ex_load),
      .wr_reg  (ex_load_dst),
      .rd_en   ({st1, mem1}),
      .rd_regs ({s1_src_data, s1_src_base}),
      .hit     (lu_slot1)
   );

   hzd_reg_match #(.REG_W(REG_W), .N_RD(2), .R0_IS_ZERO(R0_IS_ZERO)) u_intra (
      .wr_en   (alu0),
      .wr_reg  (s0_dst),
      .rd_en   ({st1, mem1}),
      .rd_regs ({s1_src_data, s1_src_base}),
      .hit     (intra_dep)
   );

   hzd_issue_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .pkt_valid   (pkt_valid),
      .malformed   (malformed),
      .lu_slot0    (lu_slot0),
      .lu_slot1    (lu_slot1),
      .intra_dep   (intra_dep),
      .issue_slot0 (issue_slot0),
      .issue_slot1 (issue_slot1),
      .hold_fetch  (hold_fetch)
   );

endmodule

// File: tb/test_dual_issue_hazard_chk.sv
module test_dual_issue_hazard_chk;

   localparam int REG_W   = 3;
   localparam int ALIGN_W = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               pkt_valid = 1'b0;
   logic [ALIGN_W-1:0] pkt_pc_lo = '0;
   logic [1:0]         s0_op = 2'b00;
   logic [REG_W-1:0]   s0_dst = '0, s0_src_a = '0, s0_src_b = '0;
   logic [1:0]         s1_op = 2'b00;
   logic [REG_W-1:0]   s1_src_base = '0, s1_src_data = '0;
   logic               ex_load = 1'b0;
   logic [REG_W-1:0]   ex_load_dst = '0;
   logic               issue_slot0, issue_slot1, hold_fetch, malformed;

   int          n_chk = 0;
   int          n_bad = 0;
   logic        m_pend = 1'b0;
   logic        e_hold = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;

   dual_issue_hazard_chk #(.REG_W(REG_W), .INSTR_W(32)) i_dual_issue_hazard_chk (
      .clk, .rst_n, .pkt_valid, .pkt_pc_lo,
      .s0_op, .s0_dst, .s0_src_a, .s0_src_b,
      .s1_op, .s1_src_base, .s1_src_data,
      .ex_load, .ex_load_dst,
      .issue_slot0, .issue_slot1, .hold_fetch, .malformed
   );

   // one cycle: inputs already set at posedge+1; sample at posedge+4
   task automatic check_cycle(input string tag);
      logic mal, alu0, mem1, st1, lu0, lu1, sp, npend;
      logic [3:0] exp_v, act_v;
      string t;
      mal  = pkt_valid && (pkt_pc_lo != 0 || s0_op[1] || s1_op == 2'b01);
      alu0 = (s0_op == 2'b01);
      mem1 = s1_op[1];
      st1  = (s1_op == 2'b11);
      lu0  = ex_load && ex_load_dst != 0 && alu0 &&
             (s0_src_a == ex_load_dst || s0_src_b == ex_load_dst);
      lu1  = ex_load && ex_load_dst != 0 && mem1 &&
             (s1_src_base == ex_load_dst || (st1 && s1_src_data == ex_load_dst));
      sp   = alu0 && s0_dst != 0 && mem1 &&
             (s1_src_base == s0_dst || (st1 && s1_src_data == s0_dst));
      npend = m_pend;
      t = tag;
      if (!pkt_valid) begin
         exp_v = 4'b0000; if (t == "") t = "R10";
      end else if (mal) begin
         exp_v = 4'b0001; if (t == "") t = "R2";
      end else if (m_pend) begin
         if (lu1) exp_v = 4'b0010;
         else begin exp_v = 4'b0100; npend = 1'b0; end
         if (t == "") t = "R4";
      end else if (lu0 || lu1) begin
         exp_v = 4'b0010; if (t == "") t = "R5";
      end else if (sp) begin
         exp_v = 4'b1010; npend = 1'b1; if (t == "") t = "R3";
      end else begin
         exp_v = 4'b1100; if (t == "") t = "R1";
      end
      #3;
      act_v = {issue_slot0, issue_slot1, hold_fetch, malformed};
      n_chk++;
      if (act_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s: {issue0,issue1,hold,malformed} actual %b expected %b", t, act_v, exp_v);
      end
      e_hold = exp_v[1];
      m_pend = npend;
      @(posedge clk);
      #1;
   endtask

   // replay the packet until it is consumed; execute receives a non-load after a hold
   task automatic send(input string tag);
      check_cycle(tag);
      for (int g = 0; g < 4 && e_hold; g++) begin
         ex_load = 1'b0;
         check_cycle(tag);
      end
   endtask

   task automatic set_pkt(input logic [1:0] o0, input int d0, input int a0, input int b0,
                          input logic [1:0] o1, input int ba, input int da);
      pkt_valid   = 1'b1;
      pkt_pc_lo   = '0;
      s0_op       = o0;
      s0_dst      = REG_W'(d0);
      s0_src_a    = REG_W'(a0);
      s0_src_b    = REG_W'(b0);
      s1_op       = o1;
      s1_src_base = REG_W'(ba);
      s1_src_data = REG_W'(da);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      m_pend = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      @(posedge clk); #1;
      check_cycle("R9");               // in reset, no packet
      do_reset();
      check_cycle("R10");              // idle after reset

      set_pkt(2'b01, 1, 2, 3, 2'b10, 4, 5);
      send("R1");                      // independent ALU + load
      set_pkt(2'b01, 1, 2, 3, 2'b11, 4, 5);
      ex_load = 1'b0; ex_load_dst = 3'd2;
      send("R6");                      // non-load producer in execute
      set_pkt(2'b01, 1, 2, 3, 2'b10, 4, 5);
      ex_load = 1'b1; ex_load_dst = 3'd3;
      send("R5");                      // load-use on slot-0 source
      set_pkt(2'b01, 1, 2, 3, 2'b11, 4, 6);
      ex_load = 1'b1; ex_load_dst = 3'd6;
      send("R5");                      // load-use on store data
      set_pkt(2'b01, 1, 2, 3, 2'b10, 4, 6);
      ex_load = 1'b1; ex_load_dst = 3'd6;
      send("R8");                      // load ignores its data field
      set_pkt(2'b00, 0, 6, 6, 2'b00, 6, 6);
      ex_load = 1'b1; ex_load_dst = 3'd6;
      send("R8");                      // nop slots ignore register fields
      set_pkt(2'b01, 5, 6, 6, 2'b00, 5, 5);
      ex_load = 1'b0;
      send("R8");                      // nop slot 1 cannot split
      set_pkt(2'b01, 3, 1, 2, 2'b10, 3, 0);
      ex_load = 1'b0;
      send("R3");                      // split, then memory half alone (R4)
      set_pkt(2'b01, 0, 0, 0, 2'b11, 0, 0);
      ex_load = 1'b1; ex_load_dst = 3'd0;
      send("R7");                      // register 0 never a dependency
      set_pkt(2'b01, 1, 2, 3, 2'b10, 4, 5);
      pkt_pc_lo = 3'd4;
      send("R2");                      // misaligned
      set_pkt(2'b10, 1, 2, 3, 2'b10, 4, 5);
      send("R2");                      // memory op in slot 0
      set_pkt(2'b01, 1, 2, 3, 2'b01, 4, 5);
      send("R2");                      // ALU op in slot 1

      // R4: load-use against the pending memory half
      set_pkt(2'b01, 3, 1, 2, 2'b11, 3, 5);
      ex_load = 1'b0;
      check_cycle("R3");
      ex_load = 1'b1; ex_load_dst = 3'd5;
      check_cycle("R4");
      ex_load = 1'b0;
      check_cycle("R4");

      // R9: reset in the middle of a split restarts the packet
      set_pkt(2'b01, 2, 1, 1, 2'b10, 2, 0);
      check_cycle("R3");
      do_reset();
      send("R9");

      // pseudo-random sweep
      for (int i = 0; i < 4000; i++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         pkt_valid = !(seed[8] && seed[9] && seed[10]);
         pkt_pc_lo = (seed[31:28] == 4'd0) ? seed[14:12] : '0;
         s0_op     = seed[5] ? seed[1:0] : {1'b0, seed[0]};
         s1_op     = seed[6] ? seed[3:2] : {seed[2], seed[2] & seed[3]};
         ex_load   = seed[7];
         seed = seed * 32'd1664525 + 32'd1013904223;
         s0_dst      = seed[31:29];
         s0_src_a    = seed[28:26];
         s0_src_b    = seed[25:23];
         s1_src_base = seed[22:20];
         s1_src_data = seed[19:17];
         ex_load_dst = seed[16:14];
         send("");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule